// File: doc/BRIEF.md
# Inter-Core Interrupt Mailbox Register Block

This block gives four cores a way to signal one another. Every core owns a bank of registers in a shared address window. The bank holds a pending-event word, a general-purpose enable word, two write-only ports, and a 32-byte message buffer. One port ORs bits into the pending word and the other removes bits from it. A core posts an interrupt to a peer by writing bits into that peer's OR port. The block raises the peer's interrupt line, and the peer takes the event, reads its message buffer, and removes the bits it has handled.

Accesses arrive on a simple request channel. Each request carries a byte address, a write flag, a size select (32-bit or 64-bit) and 64-bit write data. The block accepts a request on every cycle and returns a response one cycle later, with read data and an error flag that marks a request whose address is not aligned to its size.

Top module: `ipi_mailbox_top`

## Requirements
- R1: Address bits [9:8] select the core bank, so banks sit 0x100 bytes apart. Bits [7:0] select the register: 0x00 pending word, 0x04 enable word, 0x08 OR port, 0x0C remove port, 0x20–0x3F message buffer. An access to one bank never changes or returns another bank's state.
- R2: `req_ready` is always high. Every request with `req_valid` high yields `rsp_valid` high for exactly the next cycle. Without a request, `rsp_valid` is low. A write returns all-zero read data.
- R3: A write to the OR port ORs `req_wdata[31:0]` into that core's 32-bit pending word and raises that core's `irq_o` bit, even when the data is zero. Bits 63:32 of the write data are ignored. A pending word read returns the word zero-extended to 64 bits.
- R4: A write to the remove port clears the pending bits that are set in `req_wdata[31:0]`. The core's `irq_o` bit falls only when the resulting pending word is all zero; otherwise it keeps its value.
- R5: Reads of the OR and remove ports return zero. Writes to offset 0x00 leave the pending word and the interrupt unchanged.
- R6: The enable word is 32-bit storage: a write replaces it with `req_wdata[31:0]`, and a read returns it zero-extended.
- R7: A 64-bit access to buffer offset 0x20, 0x28, 0x30 or 0x38 reads or writes the whole 64-bit slot (offset−0x20)/8.
- R8: A 32-bit access at buffer offset 0x20+4k addresses bits 31:0 of slot k/2 when k is even and bits 63:32 when k is odd. A write stores `req_wdata[31:0]` there and keeps the other half. A read returns the half in `rsp_rdata[31:0]` with bits 63:32 zero.
- R9: A request is misaligned when `req_size`=0 and `req_addr[1:0]`≠0, or when `req_size`=1 and `req_addr[2:0]`≠0. The response then has `rsp_err`=1 and zero read data, and no register or interrupt changes.
- R10: An aligned access to any other offset (0x10–0x1F, 0x40–0xFF) reads as zero, changes nothing, and returns `rsp_err`=0.
- R11: Reset (`rst_n` low) clears every pending word, enable word and buffer slot, and drives every `irq_o` bit low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Request accepted (always high) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = 32-bit, 1 = 64-bit access |
| req_addr | input | 10 | Byte address: bank in [9:8], offset in [7:0] |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Misaligned request flag |
| irq_o | output | 4 | Interrupt line per core |

## Verification
The assertions assume that `req_valid`, `req_size` and the low address bits are always at known levels. They also assume that the interrupt lines change only through requests on the channel. The stimulus therefore drives every request field on the falling edge and holds each request for one cycle. It returns `req_valid` to zero between requests, so each response is tied to exactly one request. Misaligned and unmapped requests are included on purpose, because the properties must hold for them as well.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    // Register selected by the in-bank offset
    typedef enum logic [2:0] {
        REG_NONE   = 3'd0,
        REG_STATUS = 3'd1,
        REG_ENABLE = 3'd2,
        REG_SET    = 3'd3,
        REG_CLEAR  = 3'd4,
        REG_MBOX   = 3'd5
    } reg_kind_e;

    localparam int          BANK_OFS_W   = 8;
    localparam logic [7:0]  OFS_STATUS   = 8'h00;
    localparam logic [7:0]  OFS_ENABLE   = 8'h04;
    localparam logic [7:0]  OFS_SET      = 8'h08;
    localparam logic [7:0]  OFS_CLEAR    = 8'h0C;
    localparam logic [7:0]  OFS_MBOX_LO  = 8'h20;

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
    import ipi_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int MBOX_SLOTS = 4,
    localparam int CORE_W    = $clog2(NUM_CORES),
    localparam int SLOT_W    = $clog2(MBOX_SLOTS),
    localparam int ADDR_W    = BANK_OFS_W + CORE_W,
    localparam int MBOX_BYTES = MBOX_SLOTS * 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              size_i,
    output logic [CORE_W-1:0] core_o,
    output reg_kind_e         kind_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              half_o,
    output logic              misalign_o
);

    logic [BANK_OFS_W-1:0] ofs;
    logic [BANK_OFS_W-1:0] rel;
    logic                  in_mbox;

    always_comb begin
        ofs     = addr_i[BANK_OFS_W-1:0];
        core_o  = addr_i[BANK_OFS_W +: CORE_W];
        rel     = ofs - OFS_MBOX_LO;
        in_mbox = (ofs >= OFS_MBOX_LO) && (rel < BANK_OFS_W'(MBOX_BYTES));
        slot_o  = rel[3 +: SLOT_W];
        half_o  = rel[2];

        // Size 1 needs an 8-byte boundary, size 0 a 4-byte boundary
        misalign_o = size_i ? (addr_i[2:0] != 3'b000) : (addr_i[1:0] != 2'b00);

        if (in_mbox) begin
            kind_o = REG_MBOX;
        end else begin
            unique case (ofs)
                OFS_STATUS: kind_o = REG_STATUS;
                OFS_ENABLE: kind_o = REG_ENABLE;
                OFS_SET:    kind_o = REG_SET;
                OFS_CLEAR:  kind_o = REG_CLEAR;
                default:    kind_o = REG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ipi_core_bank.sv
module ipi_core_bank
    import ipi_pkg::*;
#(
    parameter int STATUS_W   = 32,
    parameter int DATA_W     = 64,
    parameter int MBOX_SLOTS = 4,
    localparam int SLOT_W    = $clog2(MBOX_SLOTS),
    localparam int HALF_W    = DATA_W / 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en_i,
    input  reg_kind_e                         kind_i,
    input  logic [SLOT_W-1:0]                 slot_i,
    input  logic                              half_i,
    input  logic                              size_i,
    input  logic [DATA_W-1:0]                 wdata_i,
    output logic [STATUS_W-1:0]               status_o,
    output logic [STATUS_W-1:0]               enable_o,
    output logic [MBOX_SLOTS-1:0][DATA_W-1:0] mbox_o,
    output logic                              irq_o
);

    typedef struct packed {
        logic [STATUS_W-1:0]               status;
        logic [STATUS_W-1:0]               enable;
        logic [MBOX_SLOTS-1:0][DATA_W-1:0] mbox;
        logic                              irq;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i) begin
            unique case (kind_i)
                REG_ENABLE: bank_d.enable = wdata_i[STATUS_W-1:0];
                REG_SET: begin
                    bank_d.status = bank_q.status | wdata_i[STATUS_W-1:0];
                    bank_d.irq    = 1'b1;
                end
                REG_CLEAR: begin
                    bank_d.status = bank_q.status & ~wdata_i[STATUS_W-1:0];
                    if (bank_d.status == '0) begin
                        bank_d.irq = 1'b0;
                    end
                end
                REG_MBOX: begin
                    if (size_i) begin
                        bank_d.mbox[slot_i] = wdata_i;
                    end else if (half_i) begin
                        bank_d.mbox[slot_i][DATA_W-1:HALF_W] = wdata_i[HALF_W-1:0];
                    end else begin
                        bank_d.mbox[slot_i][HALF_W-1:0] = wdata_i[HALF_W-1:0];
                    end
                end
                default: ; // status offset and unmapped offsets keep state
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign status_o = bank_q.status;
    assign enable_o = bank_q.enable;
    assign mbox_o   = bank_q.mbox;
    assign irq_o    = bank_q.irq;

endmodule

// File: rtl/ipi_read_mux.sv
module ipi_read_mux
    import ipi_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int STATUS_W   = 32,
    parameter int DATA_W     = 64,
    parameter int MBOX_SLOTS = 4,
    localparam int CORE_W    = $clog2(NUM_CORES),
    localparam int SLOT_W    = $clog2(MBOX_SLOTS),
    localparam int HALF_W    = DATA_W / 2
) (
    input  logic [CORE_W-1:0]                                core_i,
    input  reg_kind_e                                        kind_i,
    input  logic [SLOT_W-1:0]                                slot_i,
    input  logic                                             half_i,
    input  logic                                             size_i,
    input  logic [NUM_CORES-1:0][STATUS_W-1:0]               status_all_i,
    input  logic [NUM_CORES-1:0][STATUS_W-1:0]               enable_all_i,
    input  logic [NUM_CORES-1:0][MBOX_SLOTS-1:0][DATA_W-1:0] mbox_all_i,
    output logic [DATA_W-1:0]                                rdata_o
);

    logic [DATA_W-1:0] slot_word;

    always_comb begin
        slot_word = mbox_all_i[core_i][slot_i];
        unique case (kind_i)
            REG_STATUS: rdata_o = DATA_W'(status_all_i[core_i]);
            REG_ENABLE: rdata_o = DATA_W'(enable_all_i[core_i]);
            REG_MBOX: begin
                if (size_i) begin
                    rdata_o = slot_word;
                end else if (half_i) begin
                    rdata_o = DATA_W'(slot_word[DATA_W-1:HALF_W]);
                end else begin
                    rdata_o = DATA_W'(slot_word[HALF_W-1:0]);
                end
            end
            default: rdata_o = '0; // set, clear and unmapped offsets
        endcase
    end

endmodule

// File: rtl/ipi_mailbox_top.sv
module ipi_mailbox_top
    import ipi_pkg::*;
#(
    parameter int NUM_CORES  = 4,
    parameter int STATUS_W   = 32,
    parameter int DATA_W     = 64,
    parameter int MBOX_SLOTS = 4,
    localparam int CORE_W    = $clog2(NUM_CORES),
    localparam int SLOT_W    = $clog2(MBOX_SLOTS),
    localparam int ADDR_W    = BANK_OFS_W + CORE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_we,
    input  logic                 req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 rsp_err,
    output logic [NUM_CORES-1:0] irq_o
);

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    logic [CORE_W-1:0] dec_core;
    reg_kind_e         dec_kind;
    logic [SLOT_W-1:0] dec_slot;
    logic              dec_half;
    logic              dec_misalign;
    logic [DATA_W-1:0] mux_rdata;

    logic [NUM_CORES-1:0][STATUS_W-1:0]               status_all;
    logic [NUM_CORES-1:0][STATUS_W-1:0]               enable_all;
    logic [NUM_CORES-1:0][MBOX_SLOTS-1:0][DATA_W-1:0] mbox_all;

    rsp_t rsp_d, rsp_q;

    ipi_addr_decode #(
        .NUM_CORES  (NUM_CORES),
        .MBOX_SLOTS (MBOX_SLOTS)
    ) decode_i (
        .addr_i     (req_addr),
        .size_i     (req_size),
        .core_o     (dec_core),
        .kind_o     (dec_kind),
        .slot_o     (dec_slot),
        .half_o     (dec_half),
        .misalign_o (dec_misalign)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_bank
        logic bank_wr;
        assign bank_wr = req_valid && req_we && !dec_misalign && (dec_core == CORE_W'(c));

        ipi_core_bank #(
            .STATUS_W   (STATUS_W),
            .DATA_W     (DATA_W),
            .MBOX_SLOTS (MBOX_SLOTS)
        ) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en_i  (bank_wr),
            .kind_i   (dec_kind),
            .slot_i   (dec_slot),
            .half_i   (dec_half),
            .size_i   (req_size),
            .wdata_i  (req_wdata),
            .status_o (status_all[c]),
            .enable_o (enable_all[c]),
            .mbox_o   (mbox_all[c]),
            .irq_o    (irq_o[c])
        );
    end

    ipi_read_mux #(
        .NUM_CORES  (NUM_CORES),
        .STATUS_W   (STATUS_W),
        .DATA_W     (DATA_W),
        .MBOX_SLOTS (MBOX_SLOTS)
    ) rmux_i (
        .core_i       (dec_core),
        .kind_i       (dec_kind),
        .slot_i       (dec_slot),
        .half_i       (dec_half),
        .size_i       (req_size),
        .status_all_i (status_all),
        .enable_all_i (enable_all),
        .mbox_all_i   (mbox_all),
        .rdata_o      (mux_rdata)
    );

    always_comb begin
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && dec_misalign;
        rsp_d.rdata = (req_valid && !req_we && !dec_misalign) ? mux_rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign req_ready = 1'b1;
    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
    parameter int NUM_CORES = 4,
    parameter int STATUS_W  = 32,
    parameter int DATA_W    = 64
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               req_valid,
    input logic                               req_size,
    input logic [2:0]                         req_addr_lo,
    input logic                               rsp_valid,
    input logic                               rsp_err,
    input logic [DATA_W-1:0]                  rsp_rdata,
    input logic [NUM_CORES-1:0]               irq_o,
    input logic [NUM_CORES-1:0][STATUS_W-1:0] status_all
);

    logic bad_align;
    assign bad_align = req_size ? (req_addr_lo != 3'b000) : (req_addr_lo[1:0] != 2'b00);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_idle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R9
    misalign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad_align) |=> (rsp_err && rsp_rdata == '0));

    // R9
    misalign_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad_align) |=> $stable(irq_o));

    // R10
    aligned_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bad_align) |=> !rsp_err);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        // R4
        pending_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status_all[c] != '0) |-> irq_o[c]);
    end

endmodule

bind ipi_mailbox_top ipi_mailbox_chk #(
    .NUM_CORES (NUM_CORES),
    .STATUS_W  (STATUS_W),
    .DATA_W    (DATA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_size    (req_size),
    .req_addr_lo (req_addr[2:0]),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata),
    .irq_o       (irq_o),
    .status_all  (status_all)
);

// File: tb/ipi_mailbox_top_tb_top.sv
`timescale 1ns/1ps
module ipi_mailbox_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic        req_size = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_err;
    logic [3:0]  irq_o;

    always #2 clk = ~clk; // 250 MHz

    ipi_mailbox_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_we    (req_we),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic        we;
        logic        sz;
        logic [9:0]  addr;
        logic [63:0] wd;
        logic [63:0] rd;
        logic        err;
        logic [3:0]  irq;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,10'h000,64'h0,64'h0,1'b0,4'h0,8'd11},                                   // R11 pending reads 0
        '{1'b1,1'b0,10'h004,64'hA5A50F0F,64'h0,1'b0,4'h0,8'd6},                             // R6 enable write
        '{1'b0,1'b0,10'h004,64'h0,64'hA5A50F0F,1'b0,4'h0,8'd6},                             // R6 enable read
        '{1'b1,1'b1,10'h004,64'h1234,64'h0,1'b1,4'h0,8'd9},                                 // R9 64-bit at 0x04
        '{1'b0,1'b0,10'h004,64'h0,64'hA5A50F0F,1'b0,4'h0,8'd9},                             // R9 enable unchanged
        '{1'b1,1'b0,10'h108,64'h5,64'h0,1'b0,4'h2,8'd3},                                    // R3 OR port core1
        '{1'b0,1'b0,10'h100,64'h0,64'h5,1'b0,4'h2,8'd1},                                    // R1 core1 pending
        '{1'b0,1'b0,10'h000,64'h0,64'h0,1'b0,4'h2,8'd1},                                    // R1 core0 untouched
        '{1'b1,1'b0,10'h108,64'h30,64'h0,1'b0,4'h2,8'd3},                                   // R3 OR more bits
        '{1'b0,1'b0,10'h108,64'h0,64'h0,1'b0,4'h2,8'd5},                                    // R5 OR port reads 0
        '{1'b0,1'b0,10'h10C,64'h0,64'h0,1'b0,4'h2,8'd5},                                    // R5 remove port reads 0
        '{1'b1,1'b0,10'h100,64'hFF,64'h0,1'b0,4'h2,8'd5},                                   // R5 write to 0x00
        '{1'b0,1'b0,10'h100,64'h0,64'h35,1'b0,4'h2,8'd5},                                   // R5 pending kept
        '{1'b1,1'b0,10'h10C,64'h5,64'h0,1'b0,4'h2,8'd4},                                    // R4 partial remove
        '{1'b0,1'b0,10'h100,64'h0,64'h30,1'b0,4'h2,8'd4},                                   // R4
        '{1'b1,1'b0,10'h10C,64'hFFFFFFFF,64'h0,1'b0,4'h0,8'd4},                             // R4 full remove drops irq
        '{1'b0,1'b0,10'h100,64'h0,64'h0,1'b0,4'h0,8'd4},                                    // R4
        '{1'b1,1'b1,10'h228,64'h1122334455667788,64'h0,1'b0,4'h0,8'd7},                     // R7 slot write
        '{1'b0,1'b1,10'h228,64'h0,64'h1122334455667788,1'b0,4'h0,8'd7},                     // R7 slot read
        '{1'b1,1'b0,10'h22C,64'hCAFEF00D,64'h0,1'b0,4'h0,8'd8},                             // R8 high half write
        '{1'b0,1'b1,10'h228,64'h0,64'hCAFEF00D55667788,1'b0,4'h0,8'd8},                     // R8 other half kept
        '{1'b0,1'b0,10'h228,64'h0,64'h55667788,1'b0,4'h0,8'd8},                             // R8 low half read
        '{1'b0,1'b0,10'h22C,64'h0,64'hCAFEF00D,1'b0,4'h0,8'd8},                             // R8 high half read
        '{1'b1,1'b0,10'h220,64'hFFFFFFFF00000001,64'h0,1'b0,4'h0,8'd8},                     // R8 low half write
        '{1'b0,1'b1,10'h220,64'h0,64'h1,1'b0,4'h0,8'd8},                                    // R8
        '{1'b1,1'b0,10'h222,64'hDEAD,64'h0,1'b1,4'h0,8'd9},                                 // R9 32-bit misaligned
        '{1'b0,1'b1,10'h224,64'h0,64'h0,1'b1,4'h0,8'd9},                                    // R9 64-bit misaligned
        '{1'b0,1'b1,10'h220,64'h0,64'h1,1'b0,4'h0,8'd9},                                    // R9 slot unchanged
        '{1'b1,1'b0,10'h310,64'hFF,64'h0,1'b0,4'h0,8'd10},                                  // R10 unmapped write
        '{1'b0,1'b0,10'h310,64'h0,64'h0,1'b0,4'h0,8'd10},                                   // R10 unmapped read
        '{1'b0,1'b1,10'h240,64'h0,64'h0,1'b0,4'h0,8'd10},                                   // R10 past buffer
        '{1'b1,1'b1,10'h308,64'hFFFFFFFF80000000,64'h0,1'b0,4'h8,8'd3},                     // R3 upper data ignored
        '{1'b0,1'b1,10'h300,64'h0,64'h80000000,1'b0,4'h8,8'd3},                             // R3 zero-extended read
        '{1'b1,1'b0,10'h008,64'h0,64'h0,1'b0,4'h9,8'd3},                                    // R3 zero data raises irq
        '{1'b1,1'b0,10'h20A,64'h1,64'h0,1'b1,4'h9,8'd9},                                    // R9 irq held
        '{1'b1,1'b0,10'h00C,64'h0,64'h0,1'b0,4'h8,8'd4},                                    // R4 zero pending drops irq
        '{1'b0,1'b1,10'h238,64'h0,64'h0,1'b0,4'h8,8'd7}                                     // R7 untouched slot
    };

    int n_run  = 0;
    int n_fail = 0;

    task automatic check(input string what, input int rq, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic do_req(input logic we, input logic sz, input logic [9:0] addr, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_size  = sz;
        req_addr  = addr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_we    = 1'b0;
        req_wdata = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R11 state during reset
        check("irq in reset", 11, 64'(irq_o), 64'h0);
        check("rsp_valid in reset", 11, 64'(rsp_valid), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 ready always high
        check("req_ready", 2, 64'(req_ready), 64'h1);

        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i].we, VEC[i].sz, VEC[i].addr, VEC[i].wd);
            check($sformatf("vec %0d rsp_valid", i), 2, 64'(rsp_valid), 64'h1);
            check($sformatf("vec %0d rdata", i), int'(VEC[i].rq), rsp_rdata, VEC[i].rd);
            check($sformatf("vec %0d err", i), int'(VEC[i].rq), 64'(rsp_err), 64'(VEC[i].err));
            check($sformatf("vec %0d irq", i), int'(VEC[i].rq), 64'(irq_o), 64'(VEC[i].irq));
        end

        // R2 no response on an idle cycle
        @(negedge clk);
        check("idle rsp_valid", 2, 64'(rsp_valid), 64'h0);

        // R11 reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("irq after reset", 11, 64'(irq_o), 64'h0);
        rst_n = 1'b1;
        do_req(1'b0, 1'b1, 10'h228, 64'h0);
        check("slot after reset", 11, rsp_rdata, 64'h0);
        do_req(1'b0, 1'b1, 10'h300, 64'h0);
        check("pending after reset", 11, rsp_rdata, 64'h0);
        do_req(1'b0, 1'b0, 10'h004, 64'h0);
        check("enable after reset", 11, rsp_rdata, 64'h0);

        // R1 same offset, every bank: raise core2 only
        do_req(1'b1, 1'b0, 10'h208, 64'h7);
        check("core2 only irq", 1, 64'(irq_o), 64'h4);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule